// File: doc/BRIEF.md
# Banked Memory Address Decoder

This block sits between an 8-bit processor with a 16-bit address bus and the memories it reaches. Each cycle the processor may present one access (`cpu_req`, with `cpu_we` for a write). The decoder classifies the address into a region from its upper bits. It then raises the write or read strobe of exactly one target and returns that target's byte as registered read data on the following cycle.

Some targets are external and are reached through ports: the two program ROM windows, video RAM, cartridge RAM, the working-RAM array and the I/O register file. Others are held inside the block: the sprite attribute table, the high-RAM scratchpad, the interrupt-enable byte and the working-RAM bank register. The working-RAM array is seen through two 4 KiB windows: one is fixed to bank 0 and the other follows the bank register. Each window has a mirror higher in the map. Regions that are switched off, gated or unusable read back as 0xFF.

Top module: `bankmap_decode`

## Requirements
- R1: After reset `cpu_rdata` is 0xFF, `cpu_rvalid` and `bad_access` are 0, the bank register holds 1 and the interrupt-enable byte holds 0.
- R2: A read anywhere in 0x0000–0x7FFF returns `rom_rdata` with `tgt_addr` = address[13:0]. `rom_bank_sel` is 0 for 0x0000–0x3FFF (fixed bank) and 1 for 0x4000–0x7FFF (switchable bank).
- R3: A write anywhere in 0x0000–0x7FFF raises only `ctl_we`, in the same cycle, and changes no ROM data.
- R4: 0x8000–0x9FFF reaches video RAM: reads return `vram_rdata` and writes raise `vram_we`.
- R5: 0xA000–0xBFFF reaches cartridge RAM while `xram_en` is 1. While it is 0, reads return 0xFF and `xram_we` stays low.
- R6: 0xC000–0xCFFF and its mirror 0xE000–0xEFFF drive `wram_addr` = {3'b000, address[11:0]}.
- R7: 0xD000–0xDFFF and its mirror 0xF000–0xFDFF drive `wram_addr` = {bank, address[11:0]}. A read issued in the cycle right after a bank write already uses the new bank.
- R8: A write to 0xFF70 loads the bank register from data bits [2:0], and a value of 0 is stored as 1. A read of 0xFF70 returns {5'b11111, bank}. Such a write raises no `io_we`.
- R9: 0xFE00–0xFE9F is the internal sprite table. It is read and written only while `video_mode` is 0 or 1. Otherwise reads return 0xFF and writes leave the contents unchanged.
- R10: 0xFEA0–0xFEFF reads 0xFF and raises no write strobe. Any access there pulses `bad_access` high for exactly the following cycle.
- R11: 0xFF00–0xFF7F, except 0xFF70, reaches the I/O port: a read raises `io_re`, a write raises `io_we`, and read data is `io_rdata`.
- R12: 0xFF80–0xFFFE is internal high RAM that stores and returns bytes.
- R13: 0xFFFF is the internal interrupt-enable byte, separate from high RAM.
- R14: Read data appears on `cpu_rdata` with `cpu_rvalid` = 1 one cycle after the read request. A write leaves `cpu_rvalid` 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Access request this cycle |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 16 | Processor address |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Registered read data |
| cpu_rvalid | output | 1 | Read data valid |
| video_mode | input | 2 | Current video mode; sprite table open for 0 and 1 |
| xram_en | input | 1 | Cartridge RAM enable |
| bad_access | output | 1 | One-cycle pulse after an unusable-area access |
| tgt_addr | output | 14 | Offset within the selected external region |
| tgt_wdata | output | 8 | Write data toward external targets |
| rom_bank_sel | output | 1 | 0 = fixed ROM bank, 1 = switchable bank |
| rom_rdata | input | 8 | ROM read data |
| ctl_we | output | 1 | Bank-controller command write strobe |
| vram_we | output | 1 | Video RAM write strobe |
| vram_rdata | input | 8 | Video RAM read data |
| xram_we | output | 1 | Cartridge RAM write strobe |
| xram_rdata | input | 8 | Cartridge RAM read data |
| wram_addr | output | 15 | Working-RAM array address {bank, offset} |
| wram_we | output | 1 | Working-RAM write strobe |
| wram_rdata | input | 8 | Working-RAM read data |
| io_re | output | 1 | I/O read strobe |
| io_we | output | 1 | I/O write strobe |
| io_rdata | input | 8 | I/O read data |

## Verification
The bank register update and the switched-window address both act on the boundary between two cycles. The bench writes a new bank value and, in the very next cycle, reads through the switched window and its mirror. It judges the result on `wram_addr` and the returned byte against the bank it computed itself. A second overlap is between sprite-table gating and the video mode. The bench changes `video_mode` in the cycle of a sprite read or write and checks both the 0xFF return and, after reopening the table, that the earlier gated write left the stored byte unchanged.

// File: rtl/bankmap_pkg.sv
package bankmap_pkg;

    typedef enum logic [3:0] {
        RG_ROM_FIXED,
        RG_ROM_SWITCH,
        RG_VIDEO,
        RG_CART_RAM,
        RG_WORK_LOW,
        RG_WORK_HIGH,
        RG_SPRITE,
        RG_VOID,
        RG_IO,
        RG_BANK_REG,
        RG_SCRATCH,
        RG_IRQ_EN
    } region_e;

    typedef struct packed {
        logic [7:0] rdata;
        logic       rvalid;
        logic       err;
        logic [2:0] bank;
        logic [7:0] irq_en;
    } core_state_t;

endpackage

// File: rtl/region_classify.sv
module region_classify
    import bankmap_pkg::*;
#(
    parameter logic [6:0] BANK_REG_OFS = 7'h70
) (
    input  logic [15:0] addr,
    output region_e     region
);

    always_comb begin
        region = RG_VOID;
        unique case (addr[15:12])
            4'h0, 4'h1, 4'h2, 4'h3: region = RG_ROM_FIXED;
            4'h4, 4'h5, 4'h6, 4'h7: region = RG_ROM_SWITCH;
            4'h8, 4'h9:             region = RG_VIDEO;
            4'hA, 4'hB:             region = RG_CART_RAM;
            4'hC, 4'hE:             region = RG_WORK_LOW;
            4'hD:                   region = RG_WORK_HIGH;
            default: begin
                if (addr[11:8] < 4'hE) begin
                    region = RG_WORK_HIGH;
                end else if (addr[11:8] == 4'hE) begin
                    region = (addr[7:0] < 8'hA0) ? RG_SPRITE : RG_VOID;
                end else if (!addr[7]) begin
                    region = (addr[6:0] == BANK_REG_OFS) ? RG_BANK_REG : RG_IO;
                end else if (addr[6:0] == 7'h7F) begin
                    region = RG_IRQ_EN;
                end else begin
                    region = RG_SCRATCH;
                end
            end
        endcase
    end

endmodule

// File: rtl/bank_normalize.sv
module bank_normalize #(
    parameter int BANK_BITS = 3
) (
    input  logic [BANK_BITS-1:0] raw,
    output logic [BANK_BITS-1:0] bank
);

    always_comb begin
        bank = raw;
        if (raw == '0) begin
            bank = BANK_BITS'(1);
        end
    end

endmodule

// File: rtl/byte_store.sv
module byte_store #(
    parameter int DEPTH = 160,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata
);

    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we && (32'(addr) < DEPTH)) begin
            mem_q[addr] <= wdata;
        end
    end

    always_comb begin
        rdata = 8'hFF;
        if (32'(addr) < DEPTH) begin
            rdata = mem_q[addr];
        end
    end

endmodule

// File: rtl/bankmap_decode.sv
module bankmap_decode
    import bankmap_pkg::*;
#(
    parameter int         BANK_BITS    = 3,
    parameter int         SPRITE_BYTES = 160,
    parameter int         SCRATCH_BYTES = 127,
    parameter logic [6:0] BANK_REG_OFS = 7'h70
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cpu_req,
    input  logic        cpu_we,
    input  logic [15:0] cpu_addr,
    input  logic [7:0]  cpu_wdata,
    output logic [7:0]  cpu_rdata,
    output logic        cpu_rvalid,
    input  logic [1:0]  video_mode,
    input  logic        xram_en,
    output logic        bad_access,
    output logic [13:0] tgt_addr,
    output logic [7:0]  tgt_wdata,
    output logic        rom_bank_sel,
    input  logic [7:0]  rom_rdata,
    output logic        ctl_we,
    output logic        vram_we,
    input  logic [7:0]  vram_rdata,
    output logic        xram_we,
    input  logic [7:0]  xram_rdata,
    output logic [14:0] wram_addr,
    output logic        wram_we,
    input  logic [7:0]  wram_rdata,
    output logic        io_re,
    output logic        io_we,
    input  logic [7:0]  io_rdata
);

    localparam int SPRITE_AW  = $clog2(SPRITE_BYTES);
    localparam int SCRATCH_AW = $clog2(SCRATCH_BYTES);
    localparam int FILL_BITS  = 8 - BANK_BITS;

    region_e             region;
    core_state_t         st_d, st_q;
    logic [BANK_BITS-1:0] bank_new;
    logic                rd_req, wr_req;
    logic                sprite_open;
    logic                sprite_we, scratch_we;
    logic [7:0]          sprite_rd, scratch_rd;
    logic [7:0]          rd_mux;

    region_classify #(.BANK_REG_OFS(BANK_REG_OFS)) u_classify (
        .addr   (cpu_addr),
        .region (region)
    );

    bank_normalize #(.BANK_BITS(BANK_BITS)) u_bank_norm (
        .raw  (cpu_wdata[BANK_BITS-1:0]),
        .bank (bank_new)
    );

    byte_store #(.DEPTH(SPRITE_BYTES)) u_sprite (
        .clk   (clk),
        .we    (sprite_we),
        .addr  (cpu_addr[SPRITE_AW-1:0]),
        .wdata (cpu_wdata),
        .rdata (sprite_rd)
    );

    byte_store #(.DEPTH(SCRATCH_BYTES)) u_scratch (
        .clk   (clk),
        .we    (scratch_we),
        .addr  (cpu_addr[SCRATCH_AW-1:0]),
        .wdata (cpu_wdata),
        .rdata (scratch_rd)
    );

    assign rd_req      = cpu_req && !cpu_we;
    assign wr_req      = cpu_req && cpu_we;
    assign sprite_open = (video_mode < 2'd2);

    always_comb begin
        st_d         = st_q;
        st_d.err     = 1'b0;
        st_d.rvalid  = rd_req;
        rd_mux       = 8'hFF;
        ctl_we       = 1'b0;
        vram_we      = 1'b0;
        xram_we      = 1'b0;
        wram_we      = 1'b0;
        io_re        = 1'b0;
        io_we        = 1'b0;
        sprite_we    = 1'b0;
        scratch_we   = 1'b0;
        tgt_addr     = cpu_addr[13:0];
        tgt_wdata    = cpu_wdata;
        rom_bank_sel = (region == RG_ROM_SWITCH);
        wram_addr    = {((region == RG_WORK_HIGH) ? st_q.bank : BANK_BITS'(0)),
                        cpu_addr[11:0]};
        unique case (region)
            RG_ROM_FIXED, RG_ROM_SWITCH: begin
                rd_mux = rom_rdata;
                ctl_we = wr_req;
            end
            RG_VIDEO: begin
                rd_mux  = vram_rdata;
                vram_we = wr_req;
            end
            RG_CART_RAM: begin
                if (xram_en) begin
                    rd_mux  = xram_rdata;
                    xram_we = wr_req;
                end
            end
            RG_WORK_LOW, RG_WORK_HIGH: begin
                rd_mux  = wram_rdata;
                wram_we = wr_req;
            end
            RG_SPRITE: begin
                if (sprite_open) begin
                    rd_mux    = sprite_rd;
                    sprite_we = wr_req;
                end
            end
            RG_VOID: begin
                st_d.err = cpu_req;
            end
            RG_IO: begin
                rd_mux = io_rdata;
                io_re  = rd_req;
                io_we  = wr_req;
            end
            RG_BANK_REG: begin
                rd_mux = {{FILL_BITS{1'b1}}, st_q.bank};
                if (wr_req) begin
                    st_d.bank = bank_new;
                end
            end
            RG_SCRATCH: begin
                rd_mux     = scratch_rd;
                scratch_we = wr_req;
            end
            RG_IRQ_EN: begin
                rd_mux = st_q.irq_en;
                if (wr_req) begin
                    st_d.irq_en = cpu_wdata;
                end
            end
            default: begin
                rd_mux = 8'hFF;
            end
        endcase
        if (rd_req) begin
            st_d.rdata = rd_mux;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.rdata  <= 8'hFF;
            st_q.rvalid <= 1'b0;
            st_q.err    <= 1'b0;
            st_q.bank   <= BANK_BITS'(1);
            st_q.irq_en <= 8'h00;
        end else begin
            st_q <= st_d;
        end
    end

    assign cpu_rdata  = st_q.rdata;
    assign cpu_rvalid = st_q.rvalid;
    assign bad_access = st_q.err;

    assert_bank_nonzero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.bank != '0);

    assert_one_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ctl_we, vram_we, xram_we, wram_we, io_we, io_re, sprite_we, scratch_we}));

    assert_cart_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !xram_en |-> !xram_we);

    assert_sprite_closed_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && region == RG_SPRITE && !sprite_open) |=> (cpu_rdata == 8'hFF));

    assert_err_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bad_access |-> $past(cpu_req && region == RG_VOID));

    assert_read_latency_R14: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> cpu_rvalid);

endmodule

// File: tb/bankmap_decode_tb_top.sv
module bankmap_decode_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic [7:0]  cpu_rdata;
    logic        cpu_rvalid;
    logic [1:0]  video_mode = 2'd0;
    logic        xram_en = 1'b1;
    logic        bad_access;
    logic [13:0] tgt_addr;
    logic [7:0]  tgt_wdata;
    logic        rom_bank_sel;
    logic [7:0]  rom_rdata, vram_rdata, xram_rdata, wram_rdata, io_rdata;
    logic        ctl_we, vram_we, xram_we, wram_we, io_re, io_we;
    logic [14:0] wram_addr;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    logic [5:0]  s_stb;
    logic [14:0] s_waddr;
    logic        s_sel;
    logic [7:0]  s_rd;
    logic        s_rv, s_err;

    always #(CLK_PERIOD/2) clk = ~clk;

    // external memory models: data is a known function of the address seen
    assign rom_rdata  = tgt_addr[7:0] ^ (rom_bank_sel ? 8'hA5 : 8'h3C);
    assign vram_rdata = tgt_addr[7:0] ^ 8'h11;
    assign xram_rdata = tgt_addr[7:0] ^ 8'h22;
    assign io_rdata   = tgt_addr[7:0] ^ 8'h33;
    assign wram_rdata = wram_addr[7:0] ^ {wram_addr[14:12], 5'b0};

    bankmap_decode dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .cpu_rvalid(cpu_rvalid), .video_mode(video_mode), .xram_en(xram_en),
        .bad_access(bad_access), .tgt_addr(tgt_addr), .tgt_wdata(tgt_wdata),
        .rom_bank_sel(rom_bank_sel), .rom_rdata(rom_rdata), .ctl_we(ctl_we),
        .vram_we(vram_we), .vram_rdata(vram_rdata), .xram_we(xram_we),
        .xram_rdata(xram_rdata), .wram_addr(wram_addr), .wram_we(wram_we),
        .wram_rdata(wram_rdata), .io_re(io_re), .io_we(io_we), .io_rdata(io_rdata)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // one access: strobes sampled mid-cycle, registered results one cycle later
    task automatic access(input logic we, input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
        #1;
        s_stb   = {ctl_we, vram_we, xram_we, wram_we, io_we, io_re};
        s_waddr = wram_addr;
        s_sel   = rom_bank_sel;
        @(negedge clk);
        cpu_req = 1'b0; cpu_we = 1'b0;
        s_rd  = cpu_rdata;
        s_rv  = cpu_rvalid;
        s_err = bad_access;
    endtask

    task automatic t_reset();
        check("R1 rdata", cpu_rdata, 8'hFF);
        check("R1 rvalid", cpu_rvalid, 0);
        check("R1 err", bad_access, 0);
        access(0, 16'hFF70, 0); check("R1 bank", s_rd, 8'hF9);
        access(0, 16'hFFFF, 0); check("R1 irq_en", s_rd, 8'h00);
    endtask

    task automatic t_rom();
        access(0, 16'h0000, 0); check("R2 sel lo", s_sel, 0); check("R2 data 0000", s_rd, 8'h3C);
        access(0, 16'h3FFF, 0); check("R2 sel 3FFF", s_sel, 0); check("R2 data 3FFF", s_rd, 8'hC3);
        access(0, 16'h4000, 0); check("R2 sel 4000", s_sel, 1); check("R2 data 4000", s_rd, 8'hA5);
        access(0, 16'h7FFF, 0); check("R2 data 7FFF", s_rd, 8'h5A);
        access(1, 16'h2100, 8'h05); check("R3 ctl strobe only", s_stb, 6'b100000);
        access(1, 16'h7FFF, 8'h07); check("R3 ctl strobe top", s_stb, 6'b100000);
        access(0, 16'h2100, 0); check("R3 rom unchanged", s_rd, 8'h00 ^ 8'h3C);
    endtask

    task automatic t_video_cart();
        access(0, 16'h8000, 0); check("R4 read 8000", s_rd, 8'h11);
        access(0, 16'h9FFF, 0); check("R4 read 9FFF", s_rd, 8'hEE);
        access(1, 16'h9000, 8'h01); check("R4 write strobe", s_stb, 6'b010000);
        xram_en = 1'b1;
        access(0, 16'hA005, 0); check("R5 enabled read", s_rd, 8'h27);
        access(1, 16'hBFFF, 8'h9); check("R5 enabled write", s_stb, 6'b001000);
        xram_en = 1'b0;
        access(0, 16'hBFFF, 0); check("R5 disabled read", s_rd, 8'hFF);
        access(1, 16'hA000, 8'h9); check("R5 disabled write", s_stb, 6'b000000);
        xram_en = 1'b1;
    endtask

    task automatic t_work_low();
        access(0, 16'hC012, 0); check("R6 addr C012", s_waddr, 15'h0012); check("R6 data", s_rd, 8'h12);
        access(0, 16'hE012, 0); check("R6 mirror E012", s_waddr, 15'h0012);
        access(0, 16'hCFFF, 0); check("R6 addr CFFF", s_waddr, 15'h0FFF);
        access(1, 16'hEFFF, 8'h4); check("R6 mirror write", {s_stb, s_waddr}, {6'b000100, 15'h0FFF});
    endtask

    task automatic t_bank();
        access(0, 16'hD010, 0); check("R7 reset bank D010", s_waddr, 15'h1010); check("R7 data", s_rd, 8'h30);
        access(1, 16'hFF70, 8'h0D); check("R8 no io_we", s_stb, 6'b000000);
        access(0, 16'hF010, 0); check("R7 mirror bank5", s_waddr, 15'h5010); check("R7 data b5", s_rd, 8'hB0);
        access(0, 16'hFDFF, 0); check("R7 mirror top", s_waddr, 15'h5DFF);
        access(0, 16'hFF70, 0); check("R8 readback 5", s_rd, 8'hFD);
        access(1, 16'hFF70, 8'h07);
        access(0, 16'hD123, 0); check("R7 back-to-back bank7", s_waddr, 15'h7123); check("R7 data b7", s_rd, 8'hC3);
        access(1, 16'hFF70, 8'h00);
        access(0, 16'hFF70, 0); check("R8 zero maps to 1", s_rd, 8'hF9);
        access(1, 16'hFF70, 8'hF8);
        access(0, 16'hDFFF, 0); check("R8 high bits dropped", s_waddr, 15'h1FFF);
    endtask

    task automatic t_sprite();
        video_mode = 2'd0;
        access(1, 16'hFE00, 8'h5A);
        access(1, 16'hFE9F, 8'hC3);
        video_mode = 2'd1;
        access(0, 16'hFE00, 0); check("R9 mode1 read", s_rd, 8'h5A);
        video_mode = 2'd3;
        access(1, 16'hFE00, 8'h00);
        access(0, 16'hFE00, 0); check("R9 mode3 read", s_rd, 8'hFF);
        video_mode = 2'd2;
        access(0, 16'hFE9F, 0); check("R9 mode2 read", s_rd, 8'hFF);
        video_mode = 2'd0;
        access(0, 16'hFE00, 0); check("R9 gated write ignored", s_rd, 8'h5A);
        access(0, 16'hFE9F, 0); check("R9 last byte", s_rd, 8'hC3);
    endtask

    task automatic t_void();
        access(0, 16'hFDFF, 0); check("R10 no err below", s_err, 0);
        access(0, 16'hFEA0, 0); check("R10 read FF", s_rd, 8'hFF); check("R10 err read", s_err, 1);
        access(1, 16'hFEFF, 8'h3); check("R10 no strobe", s_stb, 6'b000000); check("R10 err write", s_err, 1);
        @(negedge clk); check("R10 pulse ends", bad_access, 0);
    endtask

    task automatic t_io_scratch();
        access(0, 16'hFF00, 0); check("R11 io_re", s_stb, 6'b000001); check("R11 data FF00", s_rd, 8'h33);
        access(0, 16'hFF7F, 0); check("R11 data FF7F", s_rd, 8'h4C);
        access(1, 16'hFF45, 8'h1); check("R11 io_we", s_stb, 6'b000010);
        access(1, 16'hFF80, 8'h11);
        access(1, 16'hFFFE, 8'h22);
        access(0, 16'hFF80, 0); check("R12 first byte", s_rd, 8'h11);
        access(0, 16'hFFFE, 0); check("R12 last byte", s_rd, 8'h22); check("R14 rvalid read", s_rv, 1);
        access(1, 16'hFFFF, 8'h1F); check("R14 rvalid after write", s_rv, 0);
        access(0, 16'hFFFF, 0); check("R13 irq_en", s_rd, 8'h1F);
        access(0, 16'hFFFE, 0); check("R13 scratch kept", s_rd, 8'h22);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_rom();
        t_video_cart();
        t_work_low();
        t_bank();
        t_sprite();
        t_void();
        t_io_scratch();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule